// File: doc/BRIEF.md
# PAM4-to-RS Symbol Error Signature Counter

The block watches two 2-bit PAM4 symbol streams side by side, one as sent and one as received, advancing one position on every cycle that `valid_i` is high. It packs five consecutive PAM4 positions into one 10-bit Reed-Solomon symbol and packs 544 such symbols into one codeword. Any difference inside a packed symbol marks that RS symbol as errored. The errors are counted per codeword, so the output gives the error signature a decoder would see at RS-symbol granularity, without doing any encoding or decoding.

At the close of each codeword, a one-cycle strobe carries the errored-symbol count and a flag. The flag is set when the count is higher than the correction limit of 15. Two saturating totals accumulate the number of codewords and the number of uncorrectable codewords. A sync input restarts alignment, and a clear input zeroes the totals. Typical use is in a link test path, to measure how PAM4 error bursts map onto FEC symbols.

Top module: `rs_sym_err_sig`

## Requirements
- R1: After reset, `res_valid_o` is 0, `res_errs_o` is 0, `res_uncorr_o` is 0, and both totals are 0.
- R2: An RS symbol is five consecutive accepted PAM4 positions. It is errored when `tx_sym_i` differs from `rx_sym_i` at any of those five positions. Several differing positions inside one RS symbol count as one error.
- R3: A run of differing positions that crosses from position 4 of one RS symbol into position 0 of the next RS symbol counts as two errors.
- R4: `res_valid_o` is high for exactly one cycle: the cycle after the edge that accepts the 2720th PAM4 position of a codeword (544 RS symbols times 5 positions).
- R5: `res_uncorr_o` is 1 when the codeword's errored-symbol count is 16 or more, and 0 when the count is 15 or less.
- R6: `res_errs_o` gives the errored-symbol count of the codeword, saturating at 63.
- R7: In the strobe cycle, `tot_cw_o` has already been incremented by one. `tot_uncorr_o` has also been incremented by one when the codeword is uncorrectable.
- R8: Both totals stop at all ones (2^TOT_W-1) instead of wrapping.
- R9: When `clr_tot_i` is high at an edge, both totals read 0 after that edge. This holds even if a codeword closes at the same edge.
- R10: `sync_i` high at an edge discards the partial codeword and the PAM4 position accepted at that edge. The next accepted position becomes position 0 of RS symbol 0.
- R11: Cycles with `valid_i` low neither advance alignment nor contribute errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_i | input | 1 | Restart codeword alignment |
| valid_i | input | 1 | A PAM4 symbol pair is present this cycle |
| tx_sym_i | input | 2 | Transmitted PAM4 symbol |
| rx_sym_i | input | 2 | Received PAM4 symbol |
| clr_tot_i | input | 1 | Clear both totals |
| res_valid_o | output | 1 | One-cycle codeword result strobe |
| res_errs_o | output | 6 | Errored RS symbols in the codeword, saturating |
| res_uncorr_o | output | 1 | Codeword exceeds the correction limit |
| tot_cw_o | output | TOT_W (32) | Saturating codeword total |
| tot_uncorr_o | output | TOT_W (32) | Saturating uncorrectable codeword total |

## Verification
Every codeword result, and the matching total update, is due in the single cycle right after the edge that accepts the codeword's last position. A clear shows up in the totals one edge after it is sampled. The bench drives inputs on the falling edge and reads outputs shortly after each rising edge. It reads the result directly after sending the final position, then runs one idle cycle to confirm that the strobe has dropped and occurred only once. Codeword lengths account for idle cycles, and positions discarded by sync are not counted toward them.

// File: rtl/rs_sym_err_sig.sv
module rs_sym_err_sig #(
  parameter int SYM_PER_RS = 5,
  parameter int RS_PER_CW  = 544,
  parameter int T_LIM      = 15,
  parameter int CNT_W      = 6,
  parameter int TOT_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic             valid_i,
  input  logic [1:0]       tx_sym_i,
  input  logic [1:0]       rx_sym_i,
  input  logic             clr_tot_i,
  output logic             res_valid_o,
  output logic [CNT_W-1:0] res_errs_o,
  output logic             res_uncorr_o,
  output logic [TOT_W-1:0] tot_cw_o,
  output logic [TOT_W-1:0] tot_uncorr_o
);
  localparam int POS_W = $clog2(SYM_PER_RS);
  localparam int IDX_W = $clog2(RS_PER_CW);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(SYM_PER_RS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(RS_PER_CW - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [TOT_W-1:0] TOT_MAX  = '1;

  logic [POS_W-1:0] pos_q;
  logic [IDX_W-1:0] idx_q;
  logic             acc_q;
  logic [CNT_W-1:0] cnt_q;

  wire miss   = valid_i && (tx_sym_i != rx_sym_i);
  wire rs_end = valid_i && (pos_q == POS_LAST);
  wire cw_end = rs_end && (idx_q == IDX_LAST) && !sync_i;
  wire rs_bad = acc_q || miss;
  wire [CNT_W-1:0] cnt_nxt = (rs_end && rs_bad && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;
  wire cw_unc = cnt_nxt > CNT_W'(T_LIM);

  always_ff @(posedge clk) begin
    if (!rst_n || sync_i) begin
      pos_q <= '0;
      idx_q <= '0;
      acc_q <= 1'b0;
      cnt_q <= '0;
    end else if (valid_i) begin
      if (rs_end) begin
        pos_q <= '0;
        acc_q <= 1'b0;
        idx_q <= cw_end ? '0 : idx_q + 1'b1;
        cnt_q <= cw_end ? '0 : cnt_nxt;
      end else begin
        pos_q <= pos_q + 1'b1;
        acc_q <= rs_bad;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid_o  <= 1'b0;
      res_errs_o   <= '0;
      res_uncorr_o <= 1'b0;
    end else begin
      res_valid_o <= cw_end;
      if (cw_end) begin
        res_errs_o   <= cnt_nxt;
        res_uncorr_o <= cw_unc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_tot_i) begin
      tot_cw_o     <= '0;
      tot_uncorr_o <= '0;
    end else if (cw_end) begin
      if (tot_cw_o != TOT_MAX) tot_cw_o <= tot_cw_o + 1'b1;
      if (cw_unc && tot_uncorr_o != TOT_MAX) tot_uncorr_o <= tot_uncorr_o + 1'b1;
    end
  end
endmodule

// File: rtl/rs_sym_err_sig_chk.sv
module rs_sym_err_sig_chk #(
  parameter int T_LIM = 15,
  parameter int CNT_W = 6,
  parameter int TOT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_i,
  input logic             clr_tot_i,
  input logic             res_valid_o,
  input logic [CNT_W-1:0] res_errs_o,
  input logic             res_uncorr_o,
  input logic [TOT_W-1:0] tot_cw_o,
  input logic [TOT_W-1:0] tot_uncorr_o
);
  localparam logic [TOT_W-1:0] TMAX = '1;

  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |=> !res_valid_o);

  a_r5_flag_vs_count: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> (res_uncorr_o == (res_errs_o > CNT_W'(T_LIM))));

  a_r7_cw_step: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !$past(clr_tot_i) && $past(tot_cw_o) != TMAX)
      |-> tot_cw_o == $past(tot_cw_o) + 1'b1);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid_o && !$past(clr_tot_i)) |-> ($stable(tot_cw_o) && $stable(tot_uncorr_o)));

  a_r8_unc_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    tot_uncorr_o <= tot_cw_o);

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_tot_i) |-> (tot_cw_o == '0 && tot_uncorr_o == '0));

  a_r10_sync_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sync_i) |-> !res_valid_o);
endmodule

bind rs_sym_err_sig rs_sym_err_sig_chk #(.T_LIM(T_LIM), .CNT_W(CNT_W), .TOT_W(TOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .clr_tot_i(clr_tot_i),
  .res_valid_o(res_valid_o), .res_errs_o(res_errs_o), .res_uncorr_o(res_uncorr_o),
  .tot_cw_o(tot_cw_o), .tot_uncorr_o(tot_uncorr_o));

// File: tb/rs_sym_err_sig_bench.sv
`timescale 1ns/1ps
module rs_sym_err_sig_bench;
  localparam int TW = 4;
  localparam int CW_LEN = 2720;
  localparam int TMAX = (1 << TW) - 1;

  logic clk = 0, rst_n = 0, sync_i = 0, valid_i = 0, clr_tot_i = 0;
  logic [1:0] tx_sym_i = 0, rx_sym_i = 0;
  logic res_valid_o, res_uncorr_o;
  logic [5:0] res_errs_o;
  logic [TW-1:0] tot_cw_o, tot_uncorr_o;

  int n_chk = 0, n_bad = 0, strobes = 0;
  int exp_cw = 0, exp_unc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rs_sym_err_sig #(.TOT_W(TW)) u_rs_sym_err_sig (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .valid_i(valid_i),
    .tx_sym_i(tx_sym_i), .rx_sym_i(rx_sym_i), .clr_tot_i(clr_tot_i),
    .res_valid_o(res_valid_o), .res_errs_o(res_errs_o), .res_uncorr_o(res_uncorr_o),
    .tot_cw_o(tot_cw_o), .tot_uncorr_o(tot_uncorr_o));

  always @(posedge clk) if (res_valid_o) strobes++;

  task automatic check(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit err, input int idx);
    @(negedge clk);
    valid_i  = v;
    tx_sym_i = idx[1:0];
    rx_sym_i = idx[1:0] ^ {1'b0, err};
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 0; clr_tot_i = 0; sync_i = 0;
    @(posedge clk); #1;
  endtask

  // mode 0: differing run [a, a+b); mode 1: position 2 of the first a RS symbols
  task automatic send_cw(input int mode, input int a, input int b, input bit gaps,
                         input bit clr_last, input int exp_cnt, input string r);
    int s0 = strobes;
    for (int i = 0; i < CW_LEN; i++) begin
      bit e = (mode == 0) ? (i >= a && i < a + b) : ((i / 5) < a && (i % 5) == 2);
      if (gaps && (i % 97) == 3) step(0, 1, i);
      if (i == CW_LEN - 1) clr_tot_i = clr_last;
      step(1, e, i);
      clr_tot_i = 0;
    end
    if (clr_last) begin exp_cw = 0; exp_unc = 0; end
    else begin
      if (exp_cw < TMAX) exp_cw++;
      if (exp_cnt > 15 && exp_unc < TMAX) exp_unc++;
    end
    check({r, " R4 strobe at end"}, res_valid_o, 1);
    check({r, " R6 count"}, res_errs_o, exp_cnt > 63 ? 63 : exp_cnt);
    check({r, " R5 uncorr"}, res_uncorr_o, exp_cnt > 15);
    check({r, " R7 tot_cw"}, tot_cw_o, exp_cw);
    check({r, " R7 tot_uncorr"}, tot_uncorr_o, exp_unc);
    idle();
    check({r, " R4 one cycle"}, res_valid_o, 0);
    check({r, " R4 single strobe"}, strobes - s0, 1);
  endtask

  task automatic t_reset();
    check("R1 valid", res_valid_o, 0);
    check("R1 errs", res_errs_o, 0);
    check("R1 uncorr", res_uncorr_o, 0);
    check("R1 tot_cw", tot_cw_o, 0);
    check("R1 tot_uncorr", tot_uncorr_o, 0);
  endtask

  task automatic t_inside();    send_cw(0, 10, 5, 0, 0, 1, "R2 burst inside one symbol"); endtask
  task automatic t_straddle();  send_cw(0, 4, 2, 0, 0, 2, "R3 burst across boundary"); endtask
  task automatic t_straddle5(); send_cw(0, 7, 5, 0, 0, 2, "R3 five-long burst across boundary"); endtask
  task automatic t_limit();
    send_cw(1, 15, 0, 0, 0, 15, "R5 fifteen errors");
    send_cw(1, 16, 0, 0, 0, 16, "R5 sixteen errors");
  endtask
  task automatic t_sat();       send_cw(0, 0, CW_LEN, 0, 0, 544, "R6 all symbols errored"); endtask
  task automatic t_gaps();      send_cw(1, 3, 0, 1, 0, 3, "R11 idle gaps"); endtask

  task automatic t_sync();
    for (int i = 0; i < 1000; i++) step(1, 1, i);
    @(negedge clk); sync_i = 1; valid_i = 1; rx_sym_i = ~tx_sym_i;
    @(posedge clk); #1; sync_i = 0;
    send_cw(0, 0, 0, 0, 0, 0, "R10 sync discards partial");
  endtask

  task automatic t_clear();
    send_cw(1, 20, 0, 0, 1, 20, "R9 clear wins over close");
    send_cw(0, 0, 0, 0, 0, 0, "R9 count after clear");
  endtask

  task automatic t_tot_sat();
    for (int k = 0; k < 17; k++) send_cw(1, 16, 0, 0, 0, 16, "R8 totals saturate");
    check("R8 tot_cw stays at max", tot_cw_o, TMAX);
    check("R8 tot_uncorr stays at max", tot_uncorr_o, TMAX);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    t_inside();
    t_straddle();
    t_straddle5();
    t_limit();
    t_sat();
    t_gaps();
    t_sync();
    t_clear();
    t_tot_sat();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule